// File: doc/BRIEF.md
# Configuration Mode Key Sequence Detector

This block watches I/O write cycles on a 16-bit port address and an 8-bit data bus. It recognises the unlock sequence that moves a peripheral controller into its configuration state. The sequence has two stages. First, four pre-key bytes go to the fixed port 0x279, and the last two of them choose one of three base ports. Then a 32-byte pseudo-random key goes to that chosen base port. Configuration mode is granted only after the final key byte matches.

Once the block is in configuration mode, it follows the index/data pair at the selected base port (the index is at the base address, the data at base+1). It leaves the mode when software sets bit 1 of global register 0x02. A single-cycle exit request from the surrounding register block also ends the mode. Software reads the base address output to learn where the configuration ports now live.

Top module: `cfgkey_detect`

## Requirements
- R1: After reset, `cfg_mode` is 0 and `base_addr` is 0x03F0.
- R2: The pre-key is four writes to port 0x0279. The bytes are 0x86, then 0x80, then a selector pair. The pair (0x55,0x55) selects base 0x03F0, (0x55,0xAA) selects 0x03BD and (0xAA,0x55) selects 0x0370. `base_addr` shows the new base in the cycle after the fourth write.
- R3: After the pre-key, 32 key bytes must be written in order to the selected base port. The first byte is 0x6A. Each later byte is the previous one shifted right by one bit, with the new bit 7 equal to the XOR of the old bits 0 and 1. The last byte is therefore 0x39.
- R4: `cfg_mode` goes to 1 in the cycle after the 32nd correct key byte, and never earlier.
- R5: A wrong byte at the expected port sends the detector back to idle. The expected port is 0x0279 during the pre-key and the base port during the key. After that, a complete new sequence is needed.
- R6: Outside configuration mode, 0x86 written to 0x0279 always counts as the first pre-key byte. This holds when it replaces a wrong pre-key byte, when it repeats, and when it arrives during the key stage.
- R7: Writes to unrelated addresses, cycles without `io_wr`, and key-stage writes to 0x0279 of bytes other than 0x86 all leave the match progress unchanged.
- R8: In configuration mode, writing index 0x02 to the base port and then a byte with bit 1 set to base+1 clears `cfg_mode` in the next cycle. A data byte with bit 1 clear, or any other index, has no effect.
- R9: `exit_req` high in configuration mode clears `cfg_mode` in the next cycle. Outside configuration mode it has no effect.
- R10: In configuration mode, writes to 0x0279 (including a full pre-key) change neither `base_addr` nor `cfg_mode`.
- R11: A selector pair not listed in R2, such as (0xAA,0xAA), returns the detector to idle and leaves `base_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| addr | input | 16 | Port address of the write |
| data | input | 8 | Write data |
| exit_req | input | 1 | Request from the register block to leave configuration mode |
| cfg_mode | output | 1 | Configuration mode is active |
| base_addr | output | 16 | Selected base port (index port; the data port is base+1) |

## Verification
The hardest states to reach are the late positions of the long key stage, where one byte deep inside the 32 is wrong or a restart byte lands on the pre-key port. The stimulus tasks inject a single corrupted byte at a chosen key index and then send the rest of the key correctly, which shows that the late bytes cannot rescue the sequence. A restart byte sent in the middle of the key is followed by a complete fresh sequence. Unrelated writes and idle gaps are mixed into a key stream, and each selector pair is exercised with a matching exit path. A behavioural model is compared on every clock throughout.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

   // Detector progress: pre-key positions, key stage, unlocked
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PK1  = 3'd1,
      ST_PK2  = 3'd2,
      ST_PK3  = 3'd3,
      ST_KEY  = 3'd4,
      ST_CFG  = 3'd5
   } ks_state_e;

endpackage

// File: rtl/cfgkey_base_sel.sv
// Selector-pair decoder: matches {third, fourth} pre-key bytes against a table
module cfgkey_base_sel #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int NUM_BASES = 3,
   parameter logic [NUM_BASES*ADDR_W-1:0]   BASE_LIST = '0,
   parameter logic [NUM_BASES*2*DATA_W-1:0] CODE_LIST = '0
) (
   input  logic [DATA_W-1:0]   first_byte,
   input  logic [2*DATA_W-1:0] pair,
   output logic                first_ok,
   output logic                pair_ok,
   output logic [ADDR_W-1:0]   pair_base
);
   localparam int CODE_W = 2 * DATA_W;

   logic [NUM_BASES-1:0] first_hit;
   logic [NUM_BASES-1:0] pair_hit;

   for (genvar i = 0; i < NUM_BASES; i++) begin : g_entry
      localparam logic [CODE_W-1:0] CODE = CODE_LIST[i*CODE_W +: CODE_W];
      assign first_hit[i] = (first_byte == CODE[CODE_W-1:DATA_W]);
      assign pair_hit[i]  = (pair == CODE);
   end

   assign first_ok = |first_hit;
   assign pair_ok  = |pair_hit;

   always_comb begin
      pair_base = '0;
      for (int j = NUM_BASES - 1; j >= 0; j--) begin
         if (pair_hit[j]) pair_base = BASE_LIST[j*ADDR_W +: ADDR_W];
      end
   end
endmodule

// File: rtl/cfgkey_key_gen.sv
// Expected key byte source: shift-right register with XOR feedback plus position counter
module cfgkey_key_gen #(
   parameter int DATA_W  = 8,
   parameter int KEY_LEN = 32,
   parameter logic [DATA_W-1:0] KEY_SEED = 8'h6A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [DATA_W-1:0] exp_byte,
   output logic              last
);
   localparam int CNT_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(KEY_LEN - 1);

   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  pos_q;
   logic [DATA_W-1:0] shreg_nxt;

   assign shreg_nxt = {shreg_q[0] ^ shreg_q[1], shreg_q[DATA_W-1:1]};

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         shreg_q <= KEY_SEED;
         pos_q   <= '0;
      end else if (step) begin
         shreg_q <= shreg_nxt;
         pos_q   <= pos_q + 1'b1;
      end
   end

   assign exp_byte = shreg_q;
   assign last     = (pos_q == LAST_POS);
endmodule

// File: rtl/cfgkey_exit_dec.sv
// Index/data exit decoder active only while unlocked
module cfgkey_exit_dec #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] EXIT_INDEX = 8'h02,
   parameter int EXIT_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [ADDR_W-1:0] base,
   output logic              exit_hit
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [DATA_W-1:0] index_q;
   logic              at_index;
   logic              at_data;

   assign at_index = io_wr && (addr == base);
   assign at_data  = io_wr && (addr == base + ONE);

   always_ff @(posedge clk) begin
      if (!rst_n || !active) index_q <= '0;
      else if (at_index)     index_q <= data;
   end

   assign exit_hit = active && at_data && (index_q == EXIT_INDEX) && data[EXIT_BIT];
endmodule

// File: rtl/cfgkey_detect.sv
module cfgkey_detect
   import cfgkey_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int KEY_LEN   = 32,
   parameter int NUM_BASES = 3,
   parameter logic [DATA_W-1:0] KEY_SEED   = 8'h6A,
   parameter logic [ADDR_W-1:0] PRE_PORT   = 16'h0279,
   parameter logic [DATA_W-1:0] PK_FIRST   = 8'h86,
   parameter logic [DATA_W-1:0] PK_SECOND  = 8'h80,
   parameter logic [ADDR_W-1:0] RESET_BASE = 16'h03F0,
   parameter logic [NUM_BASES*ADDR_W-1:0]   BASE_LIST = {16'h0370, 16'h03BD, 16'h03F0},
   parameter logic [NUM_BASES*2*DATA_W-1:0] CODE_LIST = {16'hAA55, 16'h55AA, 16'h5555},
   parameter logic [DATA_W-1:0] EXIT_INDEX = 8'h02,
   parameter int EXIT_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              exit_req,
   output logic              cfg_mode,
   output logic [ADDR_W-1:0] base_addr
);
   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_chk_data
      $error("DATA_W must be at least 2 for the key feedback taps");
   end
   if (KEY_LEN < 2) begin : g_chk_len
      $error("KEY_LEN must be at least 2");
   end
   if (NUM_BASES < 1) begin : g_chk_bases
      $error("NUM_BASES must be at least 1");
   end
   if (EXIT_BIT < 0 || EXIT_BIT >= DATA_W) begin : g_chk_exit
      $error("EXIT_BIT must index a bit of the data bus");
   end

   ks_state_e         st_q, st_d;
   logic [DATA_W-1:0] sel_q, sel_d;
   logic [ADDR_W-1:0] base_q, base_d;

   logic              wr_pre, wr_base, is_start;
   logic              first_ok, pair_ok;
   logic [ADDR_W-1:0] pair_base;
   logic [DATA_W-1:0] exp_byte;
   logic              key_last, key_good, key_load;
   logic              exit_hit;

   assign wr_pre   = io_wr && (addr == PRE_PORT);
   assign wr_base  = io_wr && (addr == base_q);
   assign is_start = (data == PK_FIRST);
   assign key_good = (st_q == ST_KEY) && wr_base && (data == exp_byte);
   assign key_load = (st_q != ST_KEY);

   cfgkey_base_sel #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BASES(NUM_BASES),
      .BASE_LIST(BASE_LIST), .CODE_LIST(CODE_LIST)
   ) u_sel (
      .first_byte (data),
      .pair       ({sel_q, data}),
      .first_ok   (first_ok),
      .pair_ok    (pair_ok),
      .pair_base  (pair_base)
   );

   cfgkey_key_gen #(
      .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .KEY_SEED(KEY_SEED)
   ) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (key_load),
      .step     (key_good),
      .exp_byte (exp_byte),
      .last     (key_last)
   );

   cfgkey_exit_dec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .EXIT_INDEX(EXIT_INDEX), .EXIT_BIT(EXIT_BIT)
   ) u_exit (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (st_q == ST_CFG),
      .io_wr    (io_wr),
      .addr     (addr),
      .data     (data),
      .base     (base_q),
      .exit_hit (exit_hit)
   );

   // Next-state logic
   always_comb begin
      st_d   = st_q;
      sel_d  = sel_q;
      base_d = base_q;
      unique case (st_q)
         ST_IDLE: begin
            if (wr_pre && is_start) st_d = ST_PK1;
         end
         ST_PK1: begin
            if (wr_pre) begin
               if (data == PK_SECOND) st_d = ST_PK2;
               else if (is_start)     st_d = ST_PK1;
               else                   st_d = ST_IDLE;
            end
         end
         ST_PK2: begin
            if (wr_pre) begin
               if (first_ok) begin
                  st_d  = ST_PK3;
                  sel_d = data;
               end else if (is_start) st_d = ST_PK1;
               else                   st_d = ST_IDLE;
            end
         end
         ST_PK3: begin
            if (wr_pre) begin
               if (pair_ok) begin
                  st_d   = ST_KEY;
                  base_d = pair_base;
               end else if (is_start) st_d = ST_PK1;
               else                   st_d = ST_IDLE;
            end
         end
         ST_KEY: begin
            if (wr_base) begin
               if (data != exp_byte) st_d = ST_IDLE;
               else if (key_last)    st_d = ST_CFG;
            end else if (wr_pre && is_start) begin
               st_d = ST_PK1;
            end
         end
         ST_CFG: begin
            if (exit_req || exit_hit) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sel_q  <= '0;
         base_q <= RESET_BASE;
      end else begin
         st_q   <= st_d;
         sel_q  <= sel_d;
         base_q <= base_d;
      end
   end

   assign cfg_mode  = (st_q == ST_CFG);
   assign base_addr = base_q;
endmodule

// File: rtl/cfgkey_detect_chk.sv
module cfgkey_detect_chk #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int NUM_BASES = 3,
   parameter logic [NUM_BASES*ADDR_W-1:0] BASE_LIST = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_wr,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] data,
   input logic              exit_req,
   input logic              cfg_mode,
   input logic [ADDR_W-1:0] base_addr
);
   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   function automatic logic in_list(input logic [ADDR_W-1:0] a);
      logic r = 1'b0;
      for (int i = 0; i < NUM_BASES; i++)
         if (a == BASE_LIST[i*ADDR_W +: ADDR_W]) r = 1'b1;
      return r;
   endfunction

   AST_BASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      in_list(base_addr));                                               // R2

   AST_ENTRY_ON_KEY_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      $rose(cfg_mode) |-> $past(io_wr && (addr == base_addr)));          // R4

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (!io_wr && !exit_req) |=> ($stable(cfg_mode) && $stable(base_addr))); // R7

   AST_EXIT_REQ_LEAVES: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (cfg_mode && exit_req) |=> !cfg_mode);                             // R9

   AST_BASE_FROZEN_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      cfg_mode |=> $stable(base_addr));                                  // R10

   AST_NO_CFG_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
      (!cfg_mode && !io_wr) |=> !cfg_mode);                              // R4
endmodule

bind cfgkey_detect cfgkey_detect_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BASES(NUM_BASES), .BASE_LIST(BASE_LIST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .addr(addr), .data(data),
   .exit_req(exit_req), .cfg_mode(cfg_mode), .base_addr(base_addr)
);

// File: tb/sim_cfgkey_detect.sv
`timescale 1ns/1ps
module sim_cfgkey_detect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_wr = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [7:0]  data = 8'h00;
   logic        exit_req = 1'b0;
   logic        cfg_mode;
   logic [15:0] base_addr;

   always #2 clk = ~clk;   // 250 MHz

   cfgkey_detect u0 (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .addr(addr), .data(data),
      .exit_req(exit_req), .cfg_mode(cfg_mode), .base_addr(base_addr)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // ---------------- behavioural reference ----------------
   logic [7:0]  keyb [32];
   int          m_pk, m_k;
   bit          m_inkey, m_cfg;
   logic [7:0]  m_sel, m_idx;
   logic [15:0] m_base;

   function automatic logic [15:0] pair_base(input logic [7:0] a, input logic [7:0] b);
      if (a == 8'h55 && b == 8'h55) return 16'h03F0;
      if (a == 8'h55 && b == 8'hAA) return 16'h03BD;
      if (a == 8'hAA && b == 8'h55) return 16'h0370;
      return 16'h0000;
   endfunction

   initial begin
      logic [7:0] v = 8'h6A;
      for (int i = 0; i < 32; i++) begin
         keyb[i] = v;
         v = {v[0] ^ v[1], v[7:1]};
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pk = 0; m_k = 0; m_inkey = 0; m_cfg = 0;
         m_sel = 8'h00; m_idx = 8'h00; m_base = 16'h03F0;
      end else if (m_cfg) begin
         if (exit_req) begin m_cfg = 0; m_idx = 8'h00; end
         else if (io_wr && addr == m_base) m_idx = data;
         else if (io_wr && addr == m_base + 16'd1 && m_idx == 8'h02 && data[1]) begin
            m_cfg = 0; m_idx = 8'h00;
         end
      end else if (io_wr) begin
         if (m_inkey) begin
            if (addr == m_base) begin
               if (data == keyb[m_k]) begin
                  m_k++;
                  if (m_k == 32) begin m_cfg = 1; m_inkey = 0; end
               end else begin
                  m_inkey = 0; m_pk = 0;
               end
            end else if (addr == 16'h0279 && data == 8'h86) begin
               m_inkey = 0; m_pk = 1;
            end
         end else if (addr == 16'h0279) begin
            case (m_pk)
               0: m_pk = (data == 8'h86) ? 1 : 0;
               1: m_pk = (data == 8'h80) ? 2 : (data == 8'h86) ? 1 : 0;
               2: begin
                  if (data == 8'h55 || data == 8'hAA) begin m_sel = data; m_pk = 3; end
                  else m_pk = (data == 8'h86) ? 1 : 0;
               end
               default: begin
                  if (pair_base(m_sel, data) != 16'h0000) begin
                     m_base = pair_base(m_sel, data); m_inkey = 1; m_k = 0; m_pk = 0;
                  end else m_pk = (data == 8'h86) ? 1 : 0;
               end
            endcase
         end
      end
   end

   // Compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (cfg_mode !== m_cfg || base_addr !== m_base) begin
            n_bad++;
            $display("FAIL %s model compare: cfg_mode=%0b base=%h expected cfg_mode=%0b base=%h",
                     cur_req, cfg_mode, base_addr, m_cfg, m_base);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_wr = 1'b1; addr = a; data = d;
      @(negedge clk);
      io_wr = 1'b0; addr = 16'h0000; data = 8'h00;
   endtask

   task automatic prekey(input logic [7:0] s3, input logic [7:0] s4);
      wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
      wr(16'h0279, s3);    wr(16'h0279, s4);
   endtask

   task automatic keys(input logic [15:0] b, input int from, input int upto);
      for (int i = from; i < upto; i++) wr(b, keyb[i]);
   endtask

   task automatic pulse_exit;
      @(negedge clk); exit_req = 1'b1;
      @(negedge clk); exit_req = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 cfg_mode", {15'd0, cfg_mode}, 16'h0000);
      chk("R1 base", base_addr, 16'h03F0);

      // R2 R3 R4: entry at 0x3F0
      cur_req = "R4";
      chk("R3 first key byte", {8'h00, keyb[0]}, 16'h006A);
      chk("R3 last key byte", {8'h00, keyb[31]}, 16'h0039);
      prekey(8'h55, 8'h55);
      chk("R2 base 3F0", base_addr, 16'h03F0);
      keys(16'h03F0, 0, 31);
      chk("R4 not before last byte", {15'd0, cfg_mode}, 16'h0000);
      keys(16'h03F0, 31, 32);
      chk("R4 entered", {15'd0, cfg_mode}, 16'h0001);

      // R10: pre-key while unlocked is ignored
      cur_req = "R10";
      prekey(8'hAA, 8'h55);
      chk("R10 base kept", base_addr, 16'h03F0);
      chk("R10 mode kept", {15'd0, cfg_mode}, 16'h0001);

      // R8: index/data exit
      cur_req = "R8";
      wr(16'h03F0, 8'h02); wr(16'h03F1, 8'h01);
      chk("R8 bit1 clear no exit", {15'd0, cfg_mode}, 16'h0001);
      wr(16'h03F0, 8'h07); wr(16'h03F1, 8'h02);
      chk("R8 other index no exit", {15'd0, cfg_mode}, 16'h0001);
      wr(16'h03F0, 8'h02); wr(16'h03F1, 8'h02);
      chk("R8 exit", {15'd0, cfg_mode}, 16'h0000);

      // R9: exit_req outside mode ignored, inside mode leaves
      cur_req = "R9";
      pulse_exit();
      chk("R9 idle request ignored", {15'd0, cfg_mode}, 16'h0000);
      prekey(8'h55, 8'hAA);
      chk("R2 base 3BD", base_addr, 16'h03BD);
      keys(16'h03BD, 0, 32);
      chk("R4 entered at 3BD", {15'd0, cfg_mode}, 16'h0001);
      pulse_exit();
      chk("R9 request leaves", {15'd0, cfg_mode}, 16'h0000);

      // R11: invalid selector pair
      cur_req = "R11";
      prekey(8'hAA, 8'hAA);
      chk("R11 base unchanged", base_addr, 16'h03BD);
      keys(16'h03BD, 0, 32);
      chk("R11 no entry", {15'd0, cfg_mode}, 16'h0000);

      // R7: unrelated writes, idle gaps and stray 0x279 bytes inside the key
      cur_req = "R7";
      prekey(8'hAA, 8'h55);
      chk("R2 base 370", base_addr, 16'h0370);
      for (int i = 0; i < 32; i++) begin
         wr(16'h0370, keyb[i]);
         if (i % 5 == 0) wr(16'h03F0, 8'h6A);
         if (i % 7 == 0) repeat (3) @(negedge clk);
         if (i == 12) wr(16'h0279, 8'h12);
      end
      chk("R7 entry despite noise", {15'd0, cfg_mode}, 16'h0001);
      wr(16'h0370, 8'h02); wr(16'h0371, 8'hFF);
      chk("R8 exit at 371", {15'd0, cfg_mode}, 16'h0000);

      // R5: wrong key byte deep inside the key
      cur_req = "R5";
      prekey(8'h55, 8'h55);
      keys(16'h03F0, 0, 10);
      wr(16'h03F0, keyb[10] ^ 8'h01);
      keys(16'h03F0, 11, 32);
      chk("R5 wrong key byte", {15'd0, cfg_mode}, 16'h0000);
      // wrong second pre-key byte
      wr(16'h0279, 8'h86); wr(16'h0279, 8'h81);
      wr(16'h0279, 8'h55); wr(16'h0279, 8'h55);
      keys(16'h03F0, 0, 32);
      chk("R5 wrong pre-key byte", {15'd0, cfg_mode}, 16'h0000);

      // R6: restart byte repeated and in mid-key
      cur_req = "R6";
      wr(16'h0279, 8'h86);
      prekey(8'h55, 8'h55);
      keys(16'h03F0, 0, 5);
      wr(16'h0279, 8'h86);
      keys(16'h03F0, 5, 32);
      chk("R6 mid-key restart aborts key", {15'd0, cfg_mode}, 16'h0000);
      wr(16'h0279, 8'h86);
      wr(16'h0279, 8'h86); wr(16'h0279, 8'h80);
      wr(16'h0279, 8'h55); wr(16'h0279, 8'h55);
      keys(16'h03F0, 0, 32);
      chk("R6 repeated start accepted", {15'd0, cfg_mode}, 16'h0001);
      pulse_exit();

      // R1: reset in the middle of unlocked mode
      cur_req = "R1";
      prekey(8'h55, 8'hAA);
      keys(16'h03BD, 0, 32);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R1 reset clears mode", {15'd0, cfg_mode}, 16'h0000);
      chk("R1 reset base", base_addr, 16'h03F0);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule